// File: doc/BRIEF.md
# Indexed Stroke Width Aligner

This block sets the width of horizontal and vertical strokes in a glyph outline to a programmed dot count. Software first loads a table of five stroke widths. Points then stream in. Each point carries its original X and Y coordinates, the X and Y coordinates of the reference edge it belongs to, and a 3-bit selector for each axis.

On each axis, a selector of zero leaves the coordinate as it is. A selector from 1 to 5 replaces the coordinate with the reference coordinate moved by the selected width, away from the reference on the side where the original point lies. The two axes are handled independently. A single point can therefore have its X snapped to a vertical stroke width and its Y snapped to a horizontal stroke width.

The selectors travel with the point in the same transfer. The caller has already chosen the reference edge. Register values are applied exactly as written, so any rescaling for the target glyph size is done by software. Results leave through a single registered stage with a valid/ready handshake.

Top module: `stroke_snap`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0. All five widths reset to 0, so a selector of 1 to 5 yields the reference coordinate until a width is written.
- R2: A point is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` equals `!out_valid || out_ready`. The result appears on the outputs one cycle after acceptance and stays stable while `out_valid` is 1 and `out_ready` is 0.
- R3: A selector of 0 passes that axis's original coordinate to the output unchanged.
- R4: Selector values 6 and 7 behave exactly like 0.
- R5: For a selector n from 1 to 5, when the original coordinate is greater than the reference coordinate, the output is the reference plus width n.
- R6: For a selector n from 1 to 5, when the original coordinate is less than the reference coordinate, the output is the reference minus width n.
- R7: When the original coordinate equals the reference coordinate and n is from 1 to 5, the width is added.
- R8: The X result depends only on `in_xsel`, `in_x` and `in_xref`. The Y result depends only on `in_ysel`, `in_y` and `in_yref`.
- R9: When `cfg_we` is 1, `cfg_data` is written into width `cfg_idx` for `cfg_idx` from 1 to 5. A write with `cfg_idx` of 0, 6 or 7 changes nothing. A point accepted on the same edge as a write uses the old value. Later points use the new value.
- R10: Widths are zero-extended to the coordinate width. Sums and differences wrap modulo 2^CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Width table write strobe |
| cfg_idx | input | SW | Width entry to write (1 to 5) |
| cfg_data | input | WW | Width value in dots |
| in_valid | input | 1 | Input point valid |
| in_ready | output | 1 | Block can accept a point |
| in_xsel | input | SW | X selector |
| in_ysel | input | SW | Y selector |
| in_x | input | CW | Original X coordinate |
| in_y | input | CW | Original Y coordinate |
| in_xref | input | CW | Reference edge X coordinate |
| in_yref | input | CW | Reference edge Y coordinate |
| out_valid | output | 1 | Output point valid |
| out_ready | input | 1 | Downstream accepts the output point |
| out_x | output | CW | Corrected X coordinate |
| out_y | output | CW | Corrected Y coordinate |

## Verification
The assertions assume reset is asserted before the first point. They also assume a sender keeps its point fields stable from the time it raises `in_valid` until the point is accepted. The stimulus only changes point fields after it has seen `in_ready` high in the cycle before the accepting edge. `out_ready` is toggled pseudo-randomly during the stall phase, so that holding and refilling are both exercised. Width writes are issued both between points and on the same edge as an acceptance, and they need no handshake.

// File: rtl/stroke_snap.sv
module stroke_snap #(
  parameter int CW   = 16,
  parameter int WW   = 8,
  parameter int SW   = 3,
  parameter int NREG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_idx,
  input  logic [WW-1:0] cfg_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_xsel,
  input  logic [SW-1:0] in_ysel,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  input  logic [CW-1:0] in_xref,
  input  logic [CW-1:0] in_yref,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y
);

  logic [WW-1:0] lwr [1:NREG];
  logic [WW-1:0] wx, wy;
  logic          hx, hy;
  logic [CW-1:0] nx, ny;
  logic          take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    wx = '0; wy = '0; hx = 1'b0; hy = 1'b0;
    for (int i = 1; i <= NREG; i++) begin
      if (in_xsel == SW'(i)) begin wx = lwr[i]; hx = 1'b1; end
      if (in_ysel == SW'(i)) begin wy = lwr[i]; hy = 1'b1; end
    end
  end

  function automatic logic [CW-1:0] snap(input logic hit, input logic [WW-1:0] w,
                                         input logic [CW-1:0] orig, input logic [CW-1:0] refc);
    if (!hit) return orig;
    if (orig >= refc) return refc + CW'(w);
    return refc - CW'(w);
  endfunction

  assign nx = snap(hx, wx, in_x, in_xref);
  assign ny = snap(hy, wy, in_y, in_yref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= NREG; i++) lwr[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 1; i <= NREG; i++)
        if (cfg_idx == SW'(i)) lwr[i] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_x     <= nx;
      out_y     <= ny;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y));

  // R2
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3 R4
  x_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_xsel == '0 || in_xsel > SW'(NREG)) |=> out_valid && out_x == $past(in_x));

  // R3 R4
  y_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_ysel == '0 || in_ysel > SW'(NREG)) |=> out_valid && out_y == $past(in_y));

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(!rst_n) |-> !out_valid);

endmodule

// File: tb/stroke_snap_tb.sv
module stroke_snap_tb;
  localparam int CW = 16, WW = 8, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_idx = '0;
  logic [WW-1:0] cfg_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [SW-1:0] in_xsel = '0, in_ysel = '0;
  logic [CW-1:0] in_x = '0, in_y = '0, in_xref = '0, in_yref = '0;
  logic in_ready, out_valid;
  logic [CW-1:0] out_x, out_y;

  stroke_snap #(.CW(CW), .WW(WW), .SW(SW), .NREG(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_xsel(in_xsel), .in_ysel(in_ysel),
    .in_x(in_x), .in_y(in_y), .in_xref(in_xref), .in_yref(in_yref),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0, rand_rdy = 0;
  string cur_req = "R1";

  int lwr [1:5];
  bit ev = 0;
  logic [CW-1:0] ex = '0, ey = '0;

  function automatic logic [CW-1:0] ref_fix(int sel, logic [CW-1:0] o, logic [CW-1:0] r);
    if (sel < 1 || sel > 5) return o;
    if (o >= r) return r + CW'(lwr[sel]);
    return r - CW'(lwr[sel]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ev = 0;
      for (int i = 1; i <= 5; i++) lwr[i] = 0;
    end else begin
      if (in_valid && (!ev || out_ready)) begin
        ev = 1;
        ex = ref_fix(int'(in_xsel), in_x, in_xref);
        ey = ref_fix(int'(in_ysel), in_y, in_yref);
      end else if (out_ready) ev = 0;
      if (cfg_we && cfg_idx >= 1 && cfg_idx <= 5) lwr[int'(cfg_idx)] = int'(cfg_data);
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (out_valid !== ev || in_ready !== (!ev || out_ready) ||
        (ev && (out_x !== ex || out_y !== ey))) begin
      fails++;
      $display("FAIL %s: got v=%0b r=%0b x=%h y=%h, expected v=%0b r=%0b x=%h y=%h",
               cur_req, out_valid, in_ready, out_x, out_y, ev, (!ev || out_ready), ex, ey);
    end
  end

  always @(posedge clk) if (rand_rdy) begin
    #1 out_ready = ($urandom % 3) != 0;
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 20000 && !done) begin
    fails++; checks++;
    $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
    finish_run();
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(int idx, int data);
    cfg_we = 1; cfg_idx = SW'(idx); cfg_data = WW'(data);
    tick();
    cfg_we = 0;
  endtask

  task automatic send(int xs, int ys, int x, int y, int xr, int yr);
    bit acc;
    in_valid = 1; in_xsel = SW'(xs); in_ysel = SW'(ys);
    in_x = CW'(x); in_y = CW'(y); in_xref = CW'(xr); in_yref = CW'(yr);
    do begin
      @(negedge clk); acc = in_ready;
      tick();
    end while (!acc);
    in_valid = 0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    tick();
    send(3, 2, 10, 10, 4, 20);
    tick();
    cur_req = "R9";
    wr(1, 1); wr(2, 2); wr(3, 3); wr(4, 4); wr(5, 5);
    wr(0, 99); wr(6, 77); wr(7, 66);
    for (int s = 1; s <= 5; s++) send(s, s, 100, 100, 50, 50);
    cur_req = "R3";
    send(0, 0, 123, 456, 7, 9);
    cur_req = "R4";
    send(6, 7, 321, 654, 0, 0);
    send(7, 6, 5, 6, 500, 600);
    cur_req = "R5";
    send(3, 2, 40, 40, 30, 20);
    cur_req = "R6";
    send(3, 2, 10, 10, 30, 20);
    cur_req = "R7";
    send(4, 5, 30, 20, 30, 20);
    cur_req = "R8";
    send(3, 0, 40, 999, 30, 1);
    send(0, 2, 999, 5, 1, 20);
    send(5, 1, 2, 90, 10, 80);
    cur_req = "R10";
    send(5, 5, 16'hFFFF, 0, 16'hFFFE, 2);
    wr(4, 255);
    send(4, 4, 16'hFFF0, 0, 16'hFF80, 16'h0010);
    cur_req = "R9";
    cfg_we = 1; cfg_idx = 3; cfg_data = 40;
    send(3, 3, 50, 0, 10, 10);
    cfg_we = 0;
    send(3, 3, 50, 0, 10, 10);
    tick();
    cur_req = "R2";
    rand_rdy = 1;
    for (int k = 0; k < 300; k++) begin
      if (k % 17 == 0) wr(1 + k % 5, k % 256);
      send(k % 8, (k * 3) % 8, int'($urandom % 65536), int'($urandom % 65536),
           int'($urandom % 65536), int'($urandom % 65536));
      if (k % 5 == 0) tick();
    end
    rand_rdy = 0;
    #1 out_ready = 1;
    repeat (4) tick();
    finish_run();
  end
endmodule